// File: doc/BRIEF.md
# Masked Vector Execution Sequencer

This block runs one vector instruction at a time over a small vector register file. It has a run-time element count (the active length) and an element width setting. Together these decide how many elements an instruction touches. A fixed number of parallel lanes each handles one element per cycle, and every lane receives the same control. The widest register holds `REG_BITS` bits, so the longest legal vector grows as the element width shrinks.

Four operations are provided:
- element-wise add
- element-wise subtract
- a not-equal compare that writes a one-bit-per-element flag register
- a half-move step for reductions, which copies the upper half of the active elements of one register into the low elements of another and then halves the active length

Add, subtract and half-move may be predicated by a flag register: an element is written only where its flag bit is set.

Software-visible state is loaded and observed through a whole-register write port and combinational read ports for vector and flag registers. An instruction is issued with a single-cycle `start` pulse. Completion is signalled by a one-cycle `done` pulse.

Top module: `masked_vector_sequencer`

## Requirements
- R1: After reset the active length is 0, the width code is 0 (8-bit elements, so `mvl` reads 16), all vector and flag registers read zero, and `busy` and `done` are low.
- R2: The width code selects 8, 16, 32 or 64-bit elements for codes 0, 1, 2, 3. `mvl` equals `REG_BITS/8` shifted right by the code, so 16, 8, 4 or 2 with defaults. A length request above `mvl` is stored as `mvl`, and the stored length never exceeds `mvl`.
- R3: Op code 0 (add) and op code 1 (subtract) write destination element i = source1 element i plus or minus source2 element i, modulo the element width, for every i below the active length. Element i occupies bits i·W up to i·W+W−1. Elements at or beyond the active length keep their values.
- R4: Op code 2 (compare) sets bit i of the destination flag register to 1 when source1 element i differs from source2 element i, and to 0 otherwise, for i below the active length. The compare ignores the mask input, leaves higher flag bits unchanged, and writes no vector register.
- R5: With `masked` high, add, subtract and half-move write destination element i only where bit i of the selected mask flag register is 1. The other elements keep their values.
- R6: Op code 3 (half-move) with active length N writes destination element i = source1 element ⌊N/2⌋+i for i below ⌊N/2⌋. When `done` rises, the active length reads ⌊N/2⌋.
- R7: An accepted `start` raises `busy` in the next cycle. `busy` stays high for max(1, ⌈n/LANES⌉) cycles, where n is the active length, or ⌊N/2⌋ for half-move. `done` is high for exactly the one cycle that follows, and `busy` and `done` are never high together.
- R8: While `busy` is high, `start`, register writes and configuration writes have no effect.
- R9: With an active length of 0, an instruction changes no register and signals `done` after one busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load width code and length request |
| cfg_width | input | 2 | Element width code |
| cfg_vl | input | VLW | Requested active length |
| vl | output | VLW | Current active length |
| mvl | output | VLW | Longest vector at the current width |
| start | input | 1 | Issue an instruction |
| op | input | 2 | 0 add, 1 subtract, 2 compare, 3 half-move |
| vd | input | RIW | Destination vector register |
| vs1 | input | RIW | First source vector register |
| vs2 | input | RIW | Second source vector register |
| fdst | input | FIW | Flag register written by compare |
| fmask | input | FIW | Flag register used as mask |
| masked | input | 1 | Enable per-element predication |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Write a whole vector register |
| wr_idx | input | RIW | Vector register to write |
| wr_data | input | REG_BITS | Data for the whole-register write |
| rd_idx | input | RIW | Vector register to read |
| rd_data | output | REG_BITS | Contents of the register at `rd_idx` |
| frd_idx | input | FIW | Flag register to read |
| frd_data | output | MVL_MAX | Contents of the flag register at `frd_idx` |

## Verification
The hardest states to reach from the ports combine a partial final lane group, predication from a flag register that an earlier compare produced, and a half-move on an odd length. The vector table chains entries so that a compare fills a flag register and a later masked add or half-move consumes it, with lengths chosen to leave one lane idle in the last group. A separate directed test drives `start`, a register write and a configuration write in the middle of a long instruction. It then shows, through the read ports and `vl`/`mvl`, that none of them took effect.

// File: rtl/mvs_pkg.sv
// Shared types for the masked vector sequencer.
// Assumes element widths of 8, 16, 32 and 64 bits, coded 0..3.
package mvs_pkg;

    localparam int EMAX = 64;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_CMPNE = 2'd2,
        OP_HALF  = 2'd3
    } vop_e;

    // Bit mask covering one element of the coded width
    function automatic logic [EMAX-1:0] elem_mask(input logic [1:0] w);
        case (w)
            2'd0:    elem_mask = 64'h0000_0000_0000_00FF;
            2'd1:    elem_mask = 64'h0000_0000_0000_FFFF;
            2'd2:    elem_mask = 64'h0000_0000_FFFF_FFFF;
            default: elem_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/mvs_config.sv
// Holds the element width code and the active vector length.
// Clamps a length request to the longest vector at the requested width,
// and halves the length when a half-move instruction finishes.
// Assumes cfg_we is already gated off while an instruction runs.
module mvs_config #(
    parameter int MVL_MAX = 16,
    parameter int VLW     = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_width,
    input  logic [VLW-1:0] cfg_vl,
    input  logic           finish,
    input  logic           halve,
    output logic [1:0]     width,
    output logic [VLW-1:0] vl,
    output logic [VLW-1:0] mvl
);
    logic [VLW-1:0] req_max;

    // Longest vector for the current and the requested width
    always_comb begin
        mvl     = VLW'(MVL_MAX) >> width;
        req_max = VLW'(MVL_MAX) >> cfg_width;
    end

    // Width/length register with clamping and post-half-move halving
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width <= 2'd0;
            vl    <= '0;
        end else if (cfg_we) begin
            width <= cfg_width;
            vl    <= (cfg_vl > req_max) ? req_max : cfg_vl;
        end else if (finish && halve) begin
            vl    <= vl >> 1;
        end
    end
endmodule

// File: rtl/mvs_control.sv
// Instruction sequencer: latches an issued instruction, steps the element
// index by LANES each cycle until the element count is covered, then
// pulses done. Always spends at least one cycle, even for zero elements.
module mvs_control
    import mvs_pkg::*;
#(
    parameter int LANES = 2,
    parameter int VLW   = 5,
    parameter int RIW   = 2,
    parameter int FIW   = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  vop_e           op_in,
    input  logic [RIW-1:0] vd_in,
    input  logic [RIW-1:0] vs1_in,
    input  logic [RIW-1:0] vs2_in,
    input  logic [FIW-1:0] fd_in,
    input  logic [FIW-1:0] fm_in,
    input  logic           masked_in,
    input  logic [VLW-1:0] vl,
    output logic           busy,
    output logic           done,
    output logic           finish,
    output logic [VLW-1:0] idx,
    output logic [VLW-1:0] cnt,
    output logic [VLW-1:0] half,
    output vop_e           op,
    output logic [RIW-1:0] vd,
    output logic [RIW-1:0] vs1,
    output logic [RIW-1:0] vs2,
    output logic [FIW-1:0] fd,
    output logic [FIW-1:0] fm,
    output logic           masked
);
    logic last;

    // Final group when the next step would reach the element count
    always_comb begin
        last   = ({1'b0, idx} + (VLW+1)'(LANES)) >= {1'b0, cnt};
        finish = busy && last;
    end

    // Issue, step and completion state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            idx    <= '0;
            cnt    <= '0;
            half   <= '0;
            op     <= OP_ADD;
            vd     <= '0;
            vs1    <= '0;
            vs2    <= '0;
            fd     <= '0;
            fm     <= '0;
            masked <= 1'b0;
        end else if (busy) begin
            done <= last;
            busy <= !last;
            if (!last) idx <= idx + VLW'(LANES);
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                idx    <= '0;
                half   <= vl >> 1;
                cnt    <= (op_in == OP_HALF) ? (vl >> 1) : vl;
                op     <= op_in;
                vd     <= vd_in;
                vs1    <= vs1_in;
                vs2    <= vs2_in;
                fd     <= fd_in;
                fm     <= fm_in;
                masked <= masked_in;
            end
        end
    end
endmodule

// File: rtl/mvs_lane.sv
// One lane: extracts its element from both source registers at the current
// width, computes the add/subtract/move result or the not-equal bit, and
// decides whether the element or flag bit is written.
// Assumes 'active' is false for elements at or beyond the element count.
module mvs_lane
    import mvs_pkg::*;
#(
    parameter int REG_BITS = 128,
    parameter int MVL_MAX  = 16,
    parameter int VLW      = 5
) (
    input  logic [REG_BITS-1:0] vs1_word,
    input  logic [REG_BITS-1:0] vs2_word,
    input  logic [MVL_MAX-1:0]  mask_word,
    input  logic [1:0]          width,
    input  vop_e                op,
    input  logic                masked,
    input  logic                active,
    input  logic [VLW:0]        elem,
    input  logic [VLW-1:0]      half,
    output logic                wen,
    output logic [EMAX-1:0]     wdata,
    output logic                fwen,
    output logic                fbit
);
    localparam int SHW = VLW + 8;

    logic [VLW+1:0]  src;
    logic [SHW-1:0]  sh_a, sh_b;
    logic [EMAX-1:0] em, a, b;
    logic            mbit;

    // Operand extraction at the current element width
    always_comb begin
        em   = elem_mask(width);
        src  = (op == OP_HALF) ? ({1'b0, elem} + (VLW+2)'(half)) : {1'b0, elem};
        sh_a = SHW'({src, 3'b000}) << width;
        sh_b = SHW'({elem, 3'b000}) << width;
        a    = EMAX'(vs1_word >> sh_a) & em;
        b    = EMAX'(vs2_word >> sh_b) & em;
        mbit = 1'(mask_word >> elem);
    end

    // Result and write enables for this lane
    always_comb begin
        case (op)
            OP_SUB:  wdata = (a - b) & em;
            OP_HALF: wdata = a;
            default: wdata = (a + b) & em;
        endcase
        fbit = (a != b);
        fwen = active && (op == OP_CMPNE);
        wen  = active && (op != OP_CMPNE) && (!masked || mbit);
    end
endmodule

// File: rtl/mvs_regfile.sv
// Vector and flag register storage. Merges up to LANES element writes per
// cycle into one destination register and compare bits into one flag
// register. Whole-register writes come from outside when idle.
// Assumes NREGS and NFLAGS are powers of two and REG_BITS >= 64.
module mvs_regfile
    import mvs_pkg::*;
#(
    parameter int REG_BITS = 128,
    parameter int NREGS    = 4,
    parameter int NFLAGS   = 2,
    parameter int LANES    = 2,
    parameter int MVL_MAX  = 16,
    parameter int VLW      = 5,
    parameter int RIW      = 2,
    parameter int FIW      = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ext_we,
    input  logic [RIW-1:0]             ext_idx,
    input  logic [REG_BITS-1:0]        ext_data,
    input  logic [RIW-1:0]             vd,
    input  logic [FIW-1:0]             fd,
    input  logic [1:0]                 width,
    input  logic [LANES-1:0]           wen,
    input  logic [LANES-1:0][EMAX-1:0] wdata,
    input  logic [LANES-1:0]           fwen,
    input  logic [LANES-1:0]           fbit,
    input  logic [LANES-1:0][VLW:0]    elem,
    input  logic [RIW-1:0]             vs1,
    input  logic [RIW-1:0]             vs2,
    input  logic [FIW-1:0]             fm,
    output logic [REG_BITS-1:0]        vs1_word,
    output logic [REG_BITS-1:0]        vs2_word,
    output logic [MVL_MAX-1:0]         mask_word,
    input  logic [RIW-1:0]             rd_idx,
    output logic [REG_BITS-1:0]        rd_data,
    input  logic [FIW-1:0]             frd_idx,
    output logic [MVL_MAX-1:0]         frd_data
);
    localparam int SHW = VLW + 8;

    logic [REG_BITS-1:0] vreg [NREGS];
    logic [MVL_MAX-1:0]  freg [NFLAGS];
    logic [REG_BITS-1:0] v_nxt, m;
    logic [MVL_MAX-1:0]  f_nxt;
    logic [SHW-1:0]      sh;

    // Read ports
    always_comb begin
        vs1_word  = vreg[vs1];
        vs2_word  = vreg[vs2];
        mask_word = freg[fm];
        rd_data   = vreg[rd_idx];
        frd_data  = freg[frd_idx];
    end

    // Merge lane results into the destination vector and flag registers
    always_comb begin
        v_nxt = vreg[vd];
        f_nxt = freg[fd];
        m     = '0;
        sh    = '0;
        for (int l = 0; l < LANES; l++) begin
            sh = SHW'({elem[l], 3'b000}) << width;
            if (wen[l]) begin
                m     = REG_BITS'(elem_mask(width)) << sh;
                v_nxt = (v_nxt & ~m) | ((REG_BITS'(wdata[l]) << sh) & m);
            end
            if (fwen[l]) begin
                f_nxt = (f_nxt & ~(MVL_MAX'(1) << elem[l])) |
                        (MVL_MAX'(fbit[l]) << elem[l]);
            end
        end
    end

    // Storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++)  vreg[r] <= '0;
            for (int f = 0; f < NFLAGS; f++) freg[f] <= '0;
        end else begin
            if (ext_we)     vreg[ext_idx] <= ext_data;
            else if (|wen)  vreg[vd]      <= v_nxt;
            if (|fwen)      freg[fd]      <= f_nxt;
        end
    end
endmodule

// File: rtl/masked_vector_sequencer.sv
// Top level: configuration register, instruction sequencer, LANES parallel
// element lanes and the vector/flag register file.
// Assumes start, register writes and configuration writes are only
// meaningful while idle; they are dropped while busy.
module masked_vector_sequencer
    import mvs_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int REG_BITS = 128,
    parameter int NREGS    = 4,
    parameter int NFLAGS   = 2,
    localparam int MVL_MAX = REG_BITS / 8,
    localparam int VLW     = $clog2(MVL_MAX + 1),
    localparam int RIW     = $clog2(NREGS),
    localparam int FIW     = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_width,
    input  logic [VLW-1:0]      cfg_vl,
    output logic [VLW-1:0]      vl,
    output logic [VLW-1:0]      mvl,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [RIW-1:0]      vd,
    input  logic [RIW-1:0]      vs1,
    input  logic [RIW-1:0]      vs2,
    input  logic [FIW-1:0]      fdst,
    input  logic [FIW-1:0]      fmask,
    input  logic                masked,
    output logic                busy,
    output logic                done,
    input  logic                wr_en,
    input  logic [RIW-1:0]      wr_idx,
    input  logic [REG_BITS-1:0] wr_data,
    input  logic [RIW-1:0]      rd_idx,
    output logic [REG_BITS-1:0] rd_data,
    input  logic [FIW-1:0]      frd_idx,
    output logic [MVL_MAX-1:0]  frd_data
);
    logic [1:0]                 width;
    logic                       finish;
    logic [VLW-1:0]             idx, cnt, half;
    vop_e                       op_q;
    logic [RIW-1:0]             vd_q, vs1_q, vs2_q;
    logic [FIW-1:0]             fd_q, fm_q;
    logic                       masked_q;
    logic [REG_BITS-1:0]        vs1_word, vs2_word;
    logic [MVL_MAX-1:0]         mask_word;
    logic [LANES-1:0]           l_wen, l_fwen, l_fbit, l_act;
    logic [LANES-1:0][EMAX-1:0] l_wdata;
    logic [LANES-1:0][VLW:0]    l_elem;

    mvs_config #(.MVL_MAX(MVL_MAX), .VLW(VLW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we && !busy), .cfg_width(cfg_width), .cfg_vl(cfg_vl),
        .finish(finish), .halve(op_q == OP_HALF),
        .width(width), .vl(vl), .mvl(mvl)
    );

    mvs_control #(.LANES(LANES), .VLW(VLW), .RIW(RIW), .FIW(FIW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(vop_e'(op)),
        .vd_in(vd), .vs1_in(vs1), .vs2_in(vs2), .fd_in(fdst), .fm_in(fmask),
        .masked_in(masked), .vl(vl),
        .busy(busy), .done(done), .finish(finish), .idx(idx), .cnt(cnt),
        .half(half), .op(op_q), .vd(vd_q), .vs1(vs1_q), .vs2(vs2_q),
        .fd(fd_q), .fm(fm_q), .masked(masked_q)
    );

    // One lane per parallel element slot
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign l_elem[l] = {1'b0, idx} + (VLW+1)'(l);
        assign l_act[l]  = busy && (l_elem[l] < {1'b0, cnt});

        mvs_lane #(.REG_BITS(REG_BITS), .MVL_MAX(MVL_MAX), .VLW(VLW)) u_lane (
            .vs1_word(vs1_word), .vs2_word(vs2_word), .mask_word(mask_word),
            .width(width), .op(op_q), .masked(masked_q), .active(l_act[l]),
            .elem(l_elem[l]), .half(half),
            .wen(l_wen[l]), .wdata(l_wdata[l]), .fwen(l_fwen[l]), .fbit(l_fbit[l])
        );
    end

    mvs_regfile #(
        .REG_BITS(REG_BITS), .NREGS(NREGS), .NFLAGS(NFLAGS), .LANES(LANES),
        .MVL_MAX(MVL_MAX), .VLW(VLW), .RIW(RIW), .FIW(FIW)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ext_we(wr_en && !busy), .ext_idx(wr_idx), .ext_data(wr_data),
        .vd(vd_q), .fd(fd_q), .width(width),
        .wen(l_wen), .wdata(l_wdata), .fwen(l_fwen), .fbit(l_fbit), .elem(l_elem),
        .vs1(vs1_q), .vs2(vs2_q), .fm(fm_q),
        .vs1_word(vs1_word), .vs2_word(vs2_word), .mask_word(mask_word),
        .rd_idx(rd_idx), .rd_data(rd_data), .frd_idx(frd_idx), .frd_data(frd_data)
    );
endmodule

// File: rtl/masked_vector_sequencer_chk.sv
// Port-level protocol and configuration properties of the sequencer.
// Attached to every instance of the top module by the bind below.
module masked_vector_sequencer_chk #(
    parameter int MVL_MAX = 16,
    parameter int VLW     = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [VLW-1:0] vl,
    input logic [VLW-1:0] mvl
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_vl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vl <= mvl);

    assert_mvl_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mvl) == 1) && (mvl >= VLW'(MVL_MAX >> 3)));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mvl));
endmodule

bind masked_vector_sequencer masked_vector_sequencer_chk #(
    .MVL_MAX(MVL_MAX), .VLW(VLW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .vl(vl), .mvl(mvl)
);

// File: tb/masked_vector_sequencer_tb.sv
// Table-driven bench with a behavioural model, then directed tests.
module masked_vector_sequencer_tb;
    localparam int RB = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_width = '0;
    logic [4:0]    cfg_vl = '0;
    logic [4:0]    vl, mvl;
    logic          start = 1'b0;
    logic [1:0]    op = '0;
    logic [1:0]    vd = '0, vs1 = '0, vs2 = '0;
    logic          fdst = 1'b0, fmask = 1'b0, masked = 1'b0;
    logic          busy, done;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_idx = '0;
    logic [RB-1:0] wr_data = '0;
    logic [1:0]    rd_idx = '0;
    logic [RB-1:0] rd_data;
    logic          frd_idx = 1'b0;
    logic [15:0]   frd_data;

    int applied = 0;
    int fails = 0;

    logic [RB-1:0] m_v [4];
    logic [15:0]   m_f [2];
    int            m_vl;

    always #10 clk = ~clk;

    masked_vector_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_width(cfg_width),
        .cfg_vl(cfg_vl), .vl(vl), .mvl(mvl), .start(start), .op(op),
        .vd(vd), .vs1(vs1), .vs2(vs2), .fdst(fdst), .fmask(fmask),
        .masked(masked), .busy(busy), .done(done), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .frd_idx(frd_idx), .frd_data(frd_data)
    );

    typedef struct packed {
        logic [1:0] w;
        logic [4:0] vl;
        logic [1:0] op;
        logic       msk;
        logic [1:0] vd;
        logic [1:0] s1;
        logic [1:0] s2;
        logic       fd;
        logic       fm;
        logic [7:0] cyc;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TV [NTV] = '{
        '{2'd0, 5'd16, 2'd2, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 8'd8},
        '{2'd0, 5'd16, 2'd0, 1'b0, 2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 8'd8},
        '{2'd0, 5'd10, 2'd1, 1'b1, 2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 8'd5},
        '{2'd1, 5'd5,  2'd0, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 8'd3},
        '{2'd2, 5'd9,  2'd0, 1'b1, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 8'd2},
        '{2'd3, 5'd2,  2'd1, 1'b0, 2'd3, 2'd2, 2'd1, 1'b0, 1'b0, 8'd1},
        '{2'd0, 5'd13, 2'd3, 1'b0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 8'd3},
        '{2'd1, 5'd3,  2'd2, 1'b0, 2'd0, 2'd0, 2'd3, 1'b1, 1'b0, 8'd2},
        '{2'd1, 5'd7,  2'd3, 1'b1, 2'd2, 2'd1, 2'd0, 1'b0, 1'b1, 8'd2},
        '{2'd0, 5'd0,  2'd0, 1'b0, 2'd1, 2'd2, 2'd3, 1'b0, 1'b0, 8'd1}
    };

    task automatic chk(input string req, input logic [RB-1:0] act, input logic [RB-1:0] exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] emsk(input int w);
        return (w == 3) ? '1 : ((64'd1 << (8 << w)) - 64'd1);
    endfunction

    function automatic logic [63:0] getel(input logic [RB-1:0] v, input int i, input int w);
        return 64'(v >> (i * (8 << w))) & emsk(w);
    endfunction

    function automatic logic [RB-1:0] setel(input logic [RB-1:0] v, input int i, input int w,
                                            input logic [63:0] x);
        logic [RB-1:0] mm;
        mm = RB'(emsk(w)) << (i * (8 << w));
        return (v & ~mm) | ((RB'(x & emsk(w)) << (i * (8 << w))) & mm);
    endfunction

    // Requirement-level model of one instruction
    task automatic model(input tv_t t);
        logic [RB-1:0] a, b, d;
        int n, h;
        a = m_v[t.s1]; b = m_v[t.s2]; d = m_v[t.vd];
        h = m_vl / 2;
        n = (t.op == 2'd3) ? h : m_vl;
        for (int i = 0; i < n; i++) begin
            if (t.op == 2'd2) begin
                m_f[t.fd][i] = (getel(a, i, t.w) != getel(b, i, t.w));
            end else if (!t.msk || m_f[t.fm][i]) begin
                case (t.op)
                    2'd0:    d = setel(d, i, t.w, getel(a, i, t.w) + getel(b, i, t.w));
                    2'd1:    d = setel(d, i, t.w, getel(a, i, t.w) - getel(b, i, t.w));
                    default: d = setel(d, i, t.w, getel(a, h + i, t.w));
                endcase
            end
        end
        if (t.op != 2'd2) m_v[t.vd] = d;
        if (t.op == 2'd3) m_vl = h;
    endtask

    task automatic check_state(input string req);
        for (int r = 0; r < 4; r++) begin
            rd_idx = 2'(r); #1;
            chk(req, rd_data, m_v[r]);
        end
        for (int f = 0; f < 2; f++) begin
            frd_idx = 1'(f); #1;
            chk("R4 flags", RB'(frd_data), RB'(m_f[f]));
        end
    endtask

    task automatic configure(input logic [1:0] w, input logic [4:0] req);
        int lim;
        @(negedge clk);
        cfg_we = 1'b1; cfg_width = w; cfg_vl = req;
        @(negedge clk);
        cfg_we = 1'b0;
        lim = 16 >> w;
        m_vl = (int'(req) > lim) ? lim : int'(req);
        chk("R2 mvl", RB'(mvl), RB'(lim));
        chk("R2 clamped vl", RB'(vl), RB'(m_vl));
    endtask

    task automatic issue(input tv_t t, output int cyc);
        op = t.op; vd = t.vd; vs1 = t.s1; vs2 = t.s2;
        fdst = t.fd; fmask = t.fm; masked = t.msk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done) begin
            if (busy) cyc++;
            @(negedge clk);
        end
    endtask

    task automatic wreg(input logic [1:0] r, input logic [RB-1:0] x);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = r; wr_data = x;
        @(negedge clk);
        wr_en = 1'b0;
        m_v[r] = x;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

    initial begin
        int cyc;
        string rq;
        for (int r = 0; r < 4; r++) m_v[r] = '0;
        m_f[0] = '0; m_f[1] = '0; m_vl = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 vl", RB'(vl), '0);
        chk("R1 mvl", RB'(mvl), RB'(16));
        chk("R1 busy/done", RB'({busy, done}), '0);
        check_state("R1 regs");

        wreg(2'd1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        wreg(2'd2, 128'h0123_0000_89AB_FFFF_FEDC_0000_7654_FFFF);
        wreg(2'd3, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);

        // Table of stimulus with expected cycle counts
        for (int k = 0; k < NTV; k++) begin
            configure(TV[k].w, TV[k].vl);
            issue(TV[k], cyc);
            chk("R7 busy cycles", RB'(cyc), RB'(TV[k].cyc));
            model(TV[k]);
            chk("R6 vl after", RB'(vl), RB'(m_vl));
            if (TV[k].vl == 0)          rq = "R9 zero length";
            else if (TV[k].op == 2'd3)  rq = "R6 half-move";
            else if (TV[k].op == 2'd2)  rq = "R4 compare";
            else if (TV[k].msk)         rq = "R5 masked";
            else                        rq = "R3 add/sub";
            check_state(rq);
            @(negedge clk);
            chk("R7 done one cycle", RB'({busy, done}), '0);
        end

        // R8: commands during a running instruction are dropped
        configure(2'd0, 5'd16);
        op = 2'd0; vd = 2'd3; vs1 = 2'd1; vs2 = 2'd2; masked = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd1; wr_data = '0;
        cfg_we = 1'b1; cfg_width = 2'd2; cfg_vl = 5'd3;
        start = 1'b1; op = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; cfg_we = 1'b0; start = 1'b0;
        cyc = 2;
        while (!done) begin
            if (busy) cyc++;
            @(negedge clk);
        end
        model('{2'd0, 5'd16, 2'd0, 1'b0, 2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 8'd8});
        chk("R8 no restart", RB'(cyc), RB'(8));
        chk("R8 cfg ignored vl", RB'(vl), RB'(16));
        chk("R8 cfg ignored mvl", RB'(mvl), RB'(16));
        check_state("R8 write ignored");
        @(negedge clk);
        chk("R8 idle after", RB'({busy, done}), '0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule